// File: doc/BRIEF.md
# SPI Slave Shift Engine with Power-Mode Control

This block receives and transmits fixed-width serial frames as an SPI slave in mode 0. The most significant bit goes first. Incoming data is taken on the rising serial clock edge, and outgoing data changes on the falling edge. The serial clock, slave-select and data inputs are brought into the system clock domain through multi-flop synchronisers. All frame logic runs on the system clock.

Software uses a simple register interface:
- It writes one byte to send.
- It reads the last complete byte received.
- It writes a configuration word holding an enable, a slave-select enable and an idle-stop control. The idle-stop control sits at bit 13.

Sticky flags report three conditions: a write that collides with a still-pending byte, a receive overrun, and a full receive buffer.

Two power inputs drive the engine:
- **Sleep** always halts it.
- **Idle** halts it only when the idle-stop bit is set.

A halted engine, or one whose slave-select has been released, holds its bit counter at zero, so the next frame starts from the most significant bit. Halting never alters software-visible state. A byte that was pending before a halt is still sent from its first bit once the engine runs again.

Top module: `spi_slave_pm`

## Requirements
- R1: With configuration bit 0 (enable) and bit 1 (slave-select enable) set and `ss_n` low, eight serial clocks shift a byte in MSb first. That byte appears on `rx_data` with `rx_full`=1. During the same frame, `sdo` presents the pending transmit byte MSb first and `tx_pend` then clears.
- R2: `sdo_oe` is 1 only while the engine runs and is selected. With bit 1 set, selected means `ss_n` low. Otherwise `sdo_oe` is 0.
- R3: Raising `ss_n` in mid-frame clears the bit counter. The next frame receives and transmits from the MSb, and a pending transmit byte stays pending.
- R4: With configuration bit 1 clear, `ss_n` is ignored and the running engine counts as selected.
- R5: A partial or aborted frame never sets `rx_full` and never changes `rx_data`.
- R6: While `sleep_req` is 1, `sdo_oe` is 0 and serial clock edges are ignored. The transfer in progress is aborted. `rx_data`, the flags and `cfg_q` stay unchanged.
- R7: With `idle_req`=1 and configuration bit 13 clear, the engine keeps running. With bit 13 set, it stops as under sleep.
- R8: A `tx_wr` while `tx_pend`=1 sets `wcol` and discards the new byte.
- R9: A frame that completes while `rx_full`=1 sets `rov` and leaves `rx_data` holding the older byte.
- R10: `rx_rd` clears `rx_full`. A configuration write with bit 6 set clears `wcol`, and one with bit 7 set clears `rov`. Bits 6 and 7 read back as 0.
- R11: After reset, `cfg_q`, `rx_data` and all flags are 0, and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Slave select, active low (asynchronous) |
| sck | input | 1 | Serial clock, idles low (asynchronous) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| sleep_req | input | 1 | Sleep mode active |
| idle_req | input | 1 | Idle mode active |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word (bit 0 enable, bit 1 slave-select enable, bit 6/7 clear wcol/rov, bit 13 idle stop) |
| cfg_q | output | 16 | Stored configuration |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_wdata | input | 8 | Transmit byte |
| tx_pend | output | 1 | Transmit byte waiting or in flight |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| wcol | output | 1 | Write collision flag |
| rov | output | 1 | Receive overrun flag |

## Verification
The assertions assume that the power inputs and register strobes are synchronous to `clk`. They also assume the serial clock idles low and stays in each phase for several system clocks, so that every edge survives the synchroniser. The bench holds each serial clock phase for six system clocks. It drives all inputs on the falling system clock edge, changes `ss_n` and the power inputs only while `sck` is low, and waits longer than the synchroniser delay before sampling `sdo` or the flags.

// File: rtl/spi_slave_pm_pkg.sv
package spi_slave_pm_pkg;
   localparam int CFG_W        = 16;
   localparam int CFG_EN       = 0;
   localparam int CFG_SSEN     = 1;
   localparam int CFG_CLR_WCOL = 6;
   localparam int CFG_CLR_ROV  = 7;
   localparam int CFG_IDLE_STP = 13;

   localparam logic [CFG_W-1:0] CFG_KEEP =
      (CFG_W'(1) << CFG_EN) | (CFG_W'(1) << CFG_SSEN) | (CFG_W'(1) << CFG_IDLE_STP);

   typedef struct packed {
      logic tx_pend;
      logic rx_full;
      logic wcol;
      logic rov;
   } spi_flags_t;
endpackage

// File: rtl/spi_slave_pm_sync.sv
module spi_slave_pm_sync #(
   parameter int               W       = 1,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("spi_slave_pm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slave_pm_shift.sv
module spi_slave_pm_shift #(
   parameter int DW   = 8,
   parameter int CNTW = $clog2(DW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            sck_s,
   input  logic            sdi_s,
   input  logic            tx_pend,
   input  logic [DW-1:0]   tx_buf,
   output logic            sdo,
   output logic            frame_done,
   output logic            frame_used,
   output logic [DW-1:0]   rx_word,
   output logic [CNTW-1:0] bit_cnt
);
   localparam logic [CNTW-1:0] LAST = CNTW'(DW - 1);

   logic          sck_prev;
   logic          rise, fall;
   logic [DW-1:0] sh_rx, sh_tx;
   logic          inflight;

   assign rise = sck_s & ~sck_prev;
   assign fall = ~sck_s & sck_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         sh_rx    <= '0;
         inflight <= 1'b0;
      end else if (!active) begin
         bit_cnt  <= '0;
         sh_rx    <= '0;
         inflight <= 1'b0;
      end else if (rise) begin
         sh_rx <= {sh_rx[DW-2:0], sdi_s};
         if (bit_cnt == '0) inflight <= tx_pend;
         if (bit_cnt == LAST) bit_cnt <= '0;
         else                 bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_tx <= '0;
      end else if (bit_cnt == '0) begin
         if (!(active && rise)) sh_tx <= tx_pend ? tx_buf : '0;
      end else if (active && fall) begin
         sh_tx <= {sh_tx[DW-2:0], 1'b0};
      end
   end

   assign sdo        = sh_tx[DW-1];
   assign frame_done = active & rise & (bit_cnt == LAST);
   assign frame_used = inflight;
   assign rx_word    = {sh_rx[DW-2:0], sdi_s};
endmodule

// File: rtl/spi_slave_pm_regs.sv
module spi_slave_pm_regs
   import spi_slave_pm_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             tx_wr,
   input  logic [DW-1:0]    tx_wdata,
   input  logic             rx_rd,
   input  logic             frame_done,
   input  logic             frame_used,
   input  logic [DW-1:0]    rx_word,
   output logic [CFG_W-1:0] cfg_q,
   output logic [DW-1:0]    tx_buf,
   output logic [DW-1:0]    rx_buf,
   output spi_flags_t       flags
);
   logic tx_release, tx_accept, tx_collide, rx_store;

   assign tx_release = frame_done & frame_used;
   assign tx_collide = tx_wr & flags.tx_pend & ~tx_release;
   assign tx_accept  = tx_wr & ~tx_collide;
   assign rx_store   = frame_done & (~flags.rx_full | rx_rd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else if (cfg_wr) cfg_q <= cfg_wdata & CFG_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf        <= '0;
         flags.tx_pend <= 1'b0;
      end else if (tx_accept) begin
         tx_buf        <= tx_wdata;
         flags.tx_pend <= 1'b1;
      end else if (tx_release) begin
         flags.tx_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf        <= '0;
         flags.rx_full <= 1'b0;
      end else begin
         if (rx_store) rx_buf <= rx_word;
         flags.rx_full <= frame_done | (flags.rx_full & ~rx_rd);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags.wcol <= 1'b0;
         flags.rov  <= 1'b0;
      end else begin
         if (tx_collide)                            flags.wcol <= 1'b1;
         else if (cfg_wr && cfg_wdata[CFG_CLR_WCOL]) flags.wcol <= 1'b0;
         if (frame_done && flags.rx_full && !rx_rd)  flags.rov <= 1'b1;
         else if (cfg_wr && cfg_wdata[CFG_CLR_ROV])  flags.rov <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_slave_pm.sv
module spi_slave_pm
   import spi_slave_pm_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ss_n,
   input  logic             sck,
   input  logic             sdi,
   output logic             sdo,
   output logic             sdo_oe,
   input  logic             sleep_req,
   input  logic             idle_req,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_q,
   input  logic             tx_wr,
   input  logic [DW-1:0]    tx_wdata,
   output logic             tx_pend,
   input  logic             rx_rd,
   output logic [DW-1:0]    rx_data,
   output logic             rx_full,
   output logic             wcol,
   output logic             rov
);
   localparam int CNTW = $clog2(DW);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("spi_slave_pm: DW must be at least 2");
      end
   endgenerate

   logic [2:0]      pins_s;
   logic            ss_s, sck_s, sdi_s;
   logic            run, ss_rel, active;
   logic            frame_done, frame_used;
   logic [DW-1:0]   rx_word, tx_buf;
   logic [CNTW-1:0] bit_cnt;
   spi_flags_t      flags;

   spi_slave_pm_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ss_n, sck, sdi}), .q(pins_s)
   );
   assign {ss_s, sck_s, sdi_s} = pins_s;

   assign run    = cfg_q[CFG_EN] & ~sleep_req & ~(idle_req & cfg_q[CFG_IDLE_STP]);
   assign ss_rel = cfg_q[CFG_SSEN] & ss_s;
   assign active = run & ~ss_rel;

   spi_slave_pm_shift #(.DW(DW), .CNTW(CNTW)) u_shift (
      .clk(clk), .rst_n(rst_n), .active(active), .sck_s(sck_s), .sdi_s(sdi_s),
      .tx_pend(flags.tx_pend), .tx_buf(tx_buf), .sdo(sdo),
      .frame_done(frame_done), .frame_used(frame_used),
      .rx_word(rx_word), .bit_cnt(bit_cnt)
   );

   spi_slave_pm_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
      .frame_done(frame_done), .frame_used(frame_used), .rx_word(rx_word),
      .cfg_q(cfg_q), .tx_buf(tx_buf), .rx_buf(rx_data), .flags(flags)
   );

   assign sdo_oe  = active;
   assign tx_pend = flags.tx_pend;
   assign rx_full = flags.rx_full;
   assign wcol    = flags.wcol;
   assign rov     = flags.rov;
endmodule

// File: rtl/spi_slave_pm_chk.sv
module spi_slave_pm_chk #(
   parameter int DW   = 8,
   parameter int CNTW = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sleep_req,
   input logic            sdo_oe,
   input logic            active,
   input logic            tx_wr,
   input logic            tx_pend,
   input logic            wcol,
   input logic            frame_done,
   input logic            rx_full,
   input logic            rx_rd,
   input logic            rov,
   input logic [DW-1:0]   rx_data,
   input logic [CNTW-1:0] bit_cnt
);
   // R6: sleep releases the output pad
   a_r6_sleep_releases: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |-> !sdo_oe);

   // R6: receive buffer holds while asleep
   a_r6_sleep_holds_rx: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> $stable(rx_data));

   // R3: an inactive engine holds its bit counter at zero
   a_r3_counter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (bit_cnt == '0));

   // R5: the full flag rises only after a completed frame
   a_r5_full_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(frame_done));

   // R8: a write onto a pending byte collides
   a_r8_write_collides: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && tx_pend && !frame_done) |=> wcol);

   // R9: completing onto a full buffer overruns and keeps the old byte
   a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && rx_full && !rx_rd) |=> (rov && $stable(rx_data)));
endmodule

bind spi_slave_pm spi_slave_pm_chk #(.DW(DW), .CNTW(CNTW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sdo_oe(sdo_oe),
   .active(active), .tx_wr(tx_wr), .tx_pend(tx_pend), .wcol(wcol),
   .frame_done(frame_done), .rx_full(rx_full), .rx_rd(rx_rd), .rov(rov),
   .rx_data(rx_data), .bit_cnt(bit_cnt)
);

// File: tb/tb_spi_slave_pm.sv
module tb_spi_slave_pm;
   localparam int H = 6;
   localparam logic [15:0] EN = 16'h0001, SSEN = 16'h0002, CLRW = 16'h0040,
                           CLRO = 16'h0080, ISTP = 16'h2000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ss_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic sleep_req = 1'b0, idle_req = 1'b0;
   logic cfg_wr = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [7:0]  tx_wdata = '0;
   logic sdo, sdo_oe, tx_pend, rx_full, wcol, rov;
   logic [15:0] cfg_q;
   logic [7:0]  rx_data;
   logic [7:0]  seen;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   spi_slave_pm dut (
      .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .sleep_req(sleep_req), .idle_req(idle_req),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_pend(tx_pend),
      .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
      .wcol(wcol), .rov(rov)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wcfg(input logic [15:0] v);
      cfg_wdata = v; cfg_wr = 1'b1; tick(1); cfg_wr = 1'b0; tick(1);
   endtask

   task automatic wtx(input logic [7:0] v);
      tx_wdata = v; tx_wr = 1'b1; tick(1); tx_wr = 1'b0; tick(1);
   endtask

   task automatic rd_rx();
      rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(1);
   endtask

   task automatic bits(input logic [7:0] b, input int n);
      seen = '0;
      for (int i = 7; i > 7 - n; i--) begin
         sdi = b[i];
         tick(H);
         seen[i] = sdo;
         sck = 1'b1;
         tick(H);
         sck = 1'b0;
      end
      tick(H);
   endtask

   task automatic t_reset();
      chk(cfg_q == 16'h0, "R11 cfg", cfg_q, 0);
      chk({rx_full, tx_pend, wcol, rov, sdo_oe} == 5'b0, "R11 flags",
          {rx_full, tx_pend, wcol, rov, sdo_oe}, 0);
      chk(rx_data == 8'h00, "R11 rx_data", rx_data, 0);
   endtask

   task automatic t_frame();
      wcfg(EN | SSEN);
      wtx(8'hA5);
      chk(!sdo_oe, "R2 oe while ss high", sdo_oe, 0);
      ss_n = 1'b0; tick(5);
      chk(sdo_oe, "R2 oe while selected", sdo_oe, 1);
      bits(8'h3C, 8);
      chk(seen == 8'hA5, "R1 sdo msb first", seen, 8'hA5);
      chk(rx_data == 8'h3C && rx_full, "R1 rx byte", rx_data, 8'h3C);
      chk(!tx_pend, "R1 tx_pend cleared", tx_pend, 0);
      ss_n = 1'b1; tick(5);
      chk(!sdo_oe, "R2 oe released", sdo_oe, 0);
      rd_rx();
      chk(!rx_full, "R10 read clears full", rx_full, 0);
   endtask

   task automatic t_resync();
      wtx(8'h5A);
      ss_n = 1'b0; tick(5);
      bits(8'hFF, 3);
      ss_n = 1'b1; tick(5);
      chk(!rx_full && rx_data == 8'h3C, "R5 partial frame ignored", rx_data, 8'h3C);
      chk(tx_pend, "R3 pending kept", tx_pend, 1);
      ss_n = 1'b0; tick(5);
      bits(8'h81, 8);
      chk(rx_data == 8'h81, "R3 restart at msb rx", rx_data, 8'h81);
      chk(seen == 8'h5A, "R3 restart at msb tx", seen, 8'h5A);
      ss_n = 1'b1; tick(5);
      rd_rx();
   endtask

   task automatic t_wcol();
      wtx(8'h11);
      wtx(8'h22);
      chk(wcol, "R8 collision flagged", wcol, 1);
      ss_n = 1'b0; tick(5);
      bits(8'h42, 8);
      chk(seen == 8'h11, "R8 second byte discarded", seen, 8'h11);
      ss_n = 1'b1; tick(5);
      wcfg(EN | SSEN | CLRW);
      chk(!wcol && cfg_q == (EN | SSEN), "R10 wcol cleared", {wcol, cfg_q}, EN | SSEN);
   endtask

   task automatic t_ovf();
      ss_n = 1'b0; tick(5);
      bits(8'h99, 8);
      ss_n = 1'b1; tick(5);
      chk(rov, "R9 overrun flagged", rov, 1);
      chk(rx_data == 8'h42, "R9 old byte kept", rx_data, 8'h42);
      rd_rx();
      wcfg(EN | SSEN | CLRO);
      chk(!rov, "R10 rov cleared", rov, 0);
   endtask

   task automatic t_ssen_off();
      wcfg(EN);
      tick(3);
      chk(sdo_oe, "R4 selected without ss", sdo_oe, 1);
      bits(8'h6E, 8);
      chk(rx_full && rx_data == 8'h6E, "R4 frame with ss high", rx_data, 8'h6E);
      rd_rx();
      wcfg(EN | SSEN);
   endtask

   task automatic t_sleep();
      wtx(8'h77);
      ss_n = 1'b0; tick(5);
      bits(8'hF0, 4);
      sleep_req = 1'b1; tick(2);
      chk(!sdo_oe, "R6 oe released in sleep", sdo_oe, 0);
      bits(8'hFF, 8);
      chk(!rx_full && rx_data == 8'h6E, "R6 edges ignored", rx_data, 8'h6E);
      chk(tx_pend && cfg_q == (EN | SSEN), "R6 registers kept", cfg_q, EN | SSEN);
      sleep_req = 1'b0; tick(3);
      bits(8'hC3, 8);
      chk(rx_data == 8'hC3 && seen == 8'h77, "R6 restart after sleep", {rx_data, seen}, 16'hC377);
      ss_n = 1'b1; tick(5);
      rd_rx();
   endtask

   task automatic t_idle();
      idle_req = 1'b1;
      ss_n = 1'b0; tick(5);
      bits(8'h2D, 8);
      chk(rx_full && rx_data == 8'h2D, "R7 runs in idle", rx_data, 8'h2D);
      rd_rx();
      wcfg(EN | SSEN | ISTP);
      chk(!sdo_oe, "R7 stopped in idle", sdo_oe, 0);
      bits(8'hB4, 8);
      chk(!rx_full && rx_data == 8'h2D, "R7 edges ignored in idle", rx_data, 8'h2D);
      idle_req = 1'b0; tick(3);
      chk(sdo_oe, "R7 resumes after idle", sdo_oe, 1);
      ss_n = 1'b1; tick(5);
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_frame();
      t_resync();
      t_wcol();
      t_ovf();
      t_ssen_off();
      t_sleep();
      t_idle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule